// File: doc/BRIEF.md
# Power-of-Two Sample Averager

This block sits between the raw output of a converter and the result queues that follow it. Each raw sample arrives with a valid strobe and a tag that names the input it was taken from. The block adds up a run of 2^k consecutive samples that carry the same tag, divides the sum by 2^k with a right shift, and sends one averaged result downstream with its own one-cycle valid strobe and the tag of the group. Every value it sends is a finished average, so the queues downstream hold averages rather than raw samples and keep their full depth. The cost is throughput: the result rate is the sample rate divided by 2^k.

A single shift setting `cfg_shift` applies to every sequencer that feeds the block. A setting of 0 turns averaging off, and each raw sample then leaves one cycle after it arrives. Settings 1 to 6 average over 2 to 64 samples. The accumulator has six more bits than a sample, so a full group of full-scale samples cannot overflow. A change of setting, or a tag that differs from the group in progress, throws away the partial sum. The sample that arrives in that cycle starts a new group.

Top module: `sample_averager`

## Requirements
- R1: While reset is applied and in the first cycle after it, `out_valid` is low.
- R2: With `cfg_shift` = 0, every valid sample appears on `out_data` and `out_tag` one cycle after it arrives, with `out_valid` high.
- R3: With `cfg_shift` = k (1 to 6), after 2^k valid samples that carry the same tag, the block outputs floor(sum / 2^k) with that tag.
- R4: Sixty-four samples at the largest code (4095) with `cfg_shift` = 6 give 4095. The sum does not overflow.
- R5: A cycle with `in_valid` low does not count as a sample. A group may span such gaps.
- R6: `out_valid` is high for exactly one cycle per finished group. While `cfg_shift` is nonzero, `out_valid` is never high in two consecutive cycles.
- R7: A change of the effective shift discards the partial sum. A sample in the cycle of the change is the first sample of a new group under the new setting.
- R8: A valid sample whose tag differs from the tag of the group in progress discards the partial sum and becomes the first sample of a new group.
- R9: `cfg_shift` = 7 acts exactly as 6.
- R10: The result appears in the cycle after the clock edge that takes in the last sample of its group. `out_valid` is never high unless `in_valid` was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shift | input | 3 | Averaging exponent k (0 = off, 7 treated as 6) |
| in_valid | input | 1 | Raw sample strobe |
| in_data | input | 12 | Raw sample |
| in_tag | input | 4 | Input tag of the raw sample |
| out_valid | output | 1 | One-cycle strobe of a finished average |
| out_data | output | 12 | Averaged sample |
| out_tag | output | 4 | Tag of the averaged group |

## Verification
Two events can fall in the same cycle: a restart, caused by a new shift setting or a new tag, and a sample that would finish the old group or start the next one. The bench provokes this with directed cases. One changes the shift in the same cycle as a sample that would have closed the old group. Another switches the tag on what would have been the last sample of a group. Randomized runs then change the setting and the tag at random points. In each case the bench judges the result by two things: no result may appear for the discarded group, and the next result must be the average of samples taken only from the colliding cycle onward.

// File: rtl/avg_pkg.sv
package avg_pkg;

    localparam int unsigned SAMPLE_W_DEF  = 12;
    localparam int unsigned TAG_W_DEF     = 4;
    localparam int unsigned MAX_SHIFT_DEF = 6;

    // Clamp a requested exponent to the largest supported one.
    function automatic int unsigned clamp_shift(input int unsigned req,
                                                input int unsigned max_shift);
        return (req > max_shift) ? max_shift : req;
    endfunction

endpackage

// File: rtl/avg_cfg_track.sv
module avg_cfg_track #(
    parameter int unsigned MAX_SHIFT = avg_pkg::MAX_SHIFT_DEF,
    localparam int unsigned SHIFT_W  = $clog2(MAX_SHIFT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHIFT_W-1:0] cfg_shift,
    output logic [SHIFT_W-1:0] eff_shift,
    output logic               restart
);

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        eff_shift = SHIFT_W'(avg_pkg::clamp_shift(int'(cfg_shift), MAX_SHIFT));
        restart   = (eff_shift != st_q.shift);
        st_d      = st_q;
        st_d.shift = eff_shift;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
    parameter int unsigned SAMPLE_W  = avg_pkg::SAMPLE_W_DEF,
    parameter int unsigned TAG_W     = avg_pkg::TAG_W_DEF,
    parameter int unsigned MAX_SHIFT = avg_pkg::MAX_SHIFT_DEF,
    localparam int unsigned SHIFT_W  = $clog2(MAX_SHIFT + 1),
    localparam int unsigned ACC_W    = SAMPLE_W + MAX_SHIFT,
    localparam int unsigned CNT_W    = (MAX_SHIFT > 0) ? MAX_SHIFT : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic [TAG_W-1:0]    in_tag,
    input  logic [SHIFT_W-1:0]  eff_shift,
    input  logic                restart,
    output logic                group_done,
    output logic [ACC_W-1:0]    group_sum
);

    typedef struct packed {
        logic             busy;
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [TAG_W-1:0] tag;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic             fresh;
    logic [ACC_W-1:0] acc_base;
    logic [CNT_W-1:0] cnt_base;
    logic [CNT_W:0]   group_len;
    logic             is_last;

    always_comb begin
        fresh     = restart || !st_q.busy || (in_tag != st_q.tag);
        acc_base  = fresh ? '0 : st_q.acc;
        cnt_base  = fresh ? '0 : st_q.cnt;
        group_len = (CNT_W + 1)'(1) << eff_shift;
        is_last   = ({1'b0, cnt_base} == (group_len - 1'b1));
        group_sum = acc_base + ACC_W'(in_data);
        group_done = in_valid && is_last;

        st_d = st_q;
        if (in_valid) begin
            if (is_last) begin
                st_d.busy = 1'b0;
                st_d.acc  = '0;
                st_d.cnt  = '0;
            end else begin
                st_d.busy = 1'b1;
                st_d.acc  = group_sum;
                st_d.cnt  = cnt_base + 1'b1;
                st_d.tag  = in_tag;
            end
        end else if (restart) begin
            st_d.busy = 1'b0;
            st_d.acc  = '0;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/avg_result.sv
module avg_result #(
    parameter int unsigned SAMPLE_W  = avg_pkg::SAMPLE_W_DEF,
    parameter int unsigned TAG_W     = avg_pkg::TAG_W_DEF,
    parameter int unsigned MAX_SHIFT = avg_pkg::MAX_SHIFT_DEF,
    localparam int unsigned SHIFT_W  = $clog2(MAX_SHIFT + 1),
    localparam int unsigned ACC_W    = SAMPLE_W + MAX_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                group_done,
    input  logic [ACC_W-1:0]    group_sum,
    input  logic [TAG_W-1:0]    group_tag,
    input  logic [SHIFT_W-1:0]  eff_shift,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic [TAG_W-1:0]    out_tag
);

    typedef struct packed {
        logic                vld;
        logic [SAMPLE_W-1:0] data;
        logic [TAG_W-1:0]    tag;
    } res_state_t;

    res_state_t st_d, st_q;
    logic [ACC_W-1:0] scaled;

    always_comb begin
        scaled = group_sum >> eff_shift;
        st_d   = st_q;
        st_d.vld = group_done;
        if (group_done) begin
            st_d.data = scaled[SAMPLE_W-1:0];
            st_d.tag  = group_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_tag   = st_q.tag;

endmodule

// File: rtl/sample_averager.sv
module sample_averager #(
    parameter int unsigned SAMPLE_W  = avg_pkg::SAMPLE_W_DEF,
    parameter int unsigned TAG_W     = avg_pkg::TAG_W_DEF,
    parameter int unsigned MAX_SHIFT = avg_pkg::MAX_SHIFT_DEF,
    localparam int unsigned SHIFT_W  = $clog2(MAX_SHIFT + 1),
    localparam int unsigned ACC_W    = SAMPLE_W + MAX_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SHIFT_W-1:0]  cfg_shift,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic [TAG_W-1:0]    in_tag,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic [TAG_W-1:0]    out_tag
);

    logic [SHIFT_W-1:0] eff_shift;
    logic               restart;
    logic               group_done;
    logic [ACC_W-1:0]   group_sum;

    avg_cfg_track #(
        .MAX_SHIFT (MAX_SHIFT)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_shift (cfg_shift),
        .eff_shift (eff_shift),
        .restart   (restart)
    );

    avg_accum #(
        .SAMPLE_W  (SAMPLE_W),
        .TAG_W     (TAG_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_tag     (in_tag),
        .eff_shift  (eff_shift),
        .restart    (restart),
        .group_done (group_done),
        .group_sum  (group_sum)
    );

    avg_result #(
        .SAMPLE_W  (SAMPLE_W),
        .TAG_W     (TAG_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .group_done (group_done),
        .group_sum  (group_sum),
        .group_tag  (in_tag),
        .eff_shift  (eff_shift),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_tag    (out_tag)
    );

endmodule

// File: rtl/sample_averager_sva.sv
module sample_averager_sva #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned TAG_W    = 4,
    parameter int unsigned SHIFT_W  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SHIFT_W-1:0]  cfg_shift,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_data,
    input logic [TAG_W-1:0]    in_tag,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_data,
    input logic [TAG_W-1:0]    out_tag
);

    AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_shift == '0) |=>
            (out_valid && out_data == $past(in_data) && out_tag == $past(in_tag))); // R2

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_shift != '0) |=> !out_valid); // R6

    AST_RESTART_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_shift != '0 && cfg_shift != $past(cfg_shift)
         && !(cfg_shift >= SHIFT_W'(6) && $past(cfg_shift) >= SHIFT_W'(6))) |=> !out_valid); // R7

    AST_VALID_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R10

endmodule

bind sample_averager sample_averager_sva #(
    .SAMPLE_W (SAMPLE_W),
    .TAG_W    (TAG_W),
    .SHIFT_W  (SHIFT_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_shift (cfg_shift),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_tag    (in_tag),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag)
);

// File: tb/sample_averager_tb.sv
module sample_averager_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_shift = '0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic [3:0]  in_tag = '0;
    logic        out_valid;
    logic [11:0] out_data;
    logic [3:0]  out_tag;

    int errors = 0;
    int checks = 0;

    // expectation state derived from the requirements
    int          m_shift = 0;
    bit          m_busy = 0;
    int          m_cnt = 0;
    longint      m_sum = 0;
    int          m_tag = 0;
    bit          e_valid = 0;
    int          e_data = 0;
    int          e_tag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_averager u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_shift (cfg_shift),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_tag    (in_tag),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_tag   (out_tag)
    );

    function automatic int eff_of(input int s);
        return (s > 6) ? 6 : s; // R9
    endfunction

    task automatic model_step(input bit v, input int d, input int t, input int s);
        int  es;
        bit  rs;
        bit  fresh;
        longint base;
        int  cb;
        es = eff_of(s);
        rs = (es != m_shift);               // R7
        m_shift = es;
        fresh = rs || !m_busy || (t != m_tag); // R8
        base = fresh ? 0 : m_sum;
        cb = fresh ? 0 : m_cnt;
        e_valid = 0;
        if (v) begin
            if (cb == (1 << es) - 1) begin  // R3
                e_valid = 1;
                e_data = int'((base + d) >> es);
                e_tag = t;
                m_busy = 0; m_cnt = 0; m_sum = 0;
            end else begin
                m_busy = 1; m_cnt = cb + 1; m_sum = base + d; m_tag = t;
            end
        end else if (rs) begin
            m_busy = 0; m_cnt = 0; m_sum = 0;
        end
    endtask

    task automatic check_out(input string req);
        checks++;
        if (out_valid !== e_valid ||
            (e_valid && (int'(out_data) != e_data || int'(out_tag) != e_tag))) begin
            errors++;
            $display("FAIL %s: got v=%0b d=%0d t=%0d expected v=%0b d=%0d t=%0d",
                     req, out_valid, out_data, out_tag, e_valid, e_data, e_tag);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, check at next negedge
    task automatic cyc(input bit v, input int d, input int t, input int s, input string req);
        in_valid = v;
        in_data = 12'(d);
        in_tag = 4'(t);
        cfg_shift = 3'(s);
        @(posedge clk);
        model_step(v, d, t, s);
        @(negedge clk);
        check_out(req);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        int seed;
        int sh;
        seed = 1234;
        void'($urandom(seed));

        // R1: reset state
        repeat (3) @(negedge clk);
        e_valid = 0;
        check_out("R1 in reset");
        in_valid = 1; in_data = 12'd77;
        @(negedge clk);
        check_out("R1 in reset with input");
        in_valid = 0;
        rst_n = 1;
        @(negedge clk);
        check_out("R1 after reset");

        // R2: pass-through, back to back
        cyc(1, 100, 3, 0, "R2");
        cyc(1, 4095, 5, 0, "R2");
        cyc(1, 0, 1, 0, "R2");
        cyc(0, 9, 1, 0, "R10 idle");

        // R3/R5: shift 2 with gaps
        cyc(1, 10, 2, 2, "R3");
        cyc(0, 0, 2, 2, "R5 gap");
        cyc(1, 11, 2, 2, "R5");
        cyc(0, 0, 2, 2, "R5 gap");
        cyc(1, 12, 2, 2, "R3");
        cyc(1, 14, 2, 2, "R3 done 47/4=11");
        cyc(0, 0, 2, 2, "R6 single pulse");

        // R4: 64 full-scale samples
        for (int i = 0; i < 64; i++) cyc(1, 4095, 7, 6, "R4");
        cyc(0, 0, 7, 6, "R6");

        // R7: shift change in cycle that would close old group
        cyc(1, 1, 4, 1, "R7");
        cyc(1, 3, 4, 2, "R7 change collides");
        cyc(1, 5, 4, 2, "R7");
        cyc(1, 7, 4, 2, "R7");
        cyc(1, 9, 4, 2, "R7 new group result");

        // R8: tag switch on would-be last sample
        cyc(1, 20, 1, 1, "R8");
        cyc(1, 30, 2, 1, "R8 tag collides");
        cyc(1, 40, 2, 1, "R8 result 35");

        // R9: shift 7 equals 6, switching 6<->7 keeps group
        for (int i = 0; i < 32; i++) cyc(1, i, 3, 6, "R9");
        for (int i = 0; i < 32; i++) cyc(1, 100 + i, 3, 7, "R9");
        cyc(0, 0, 3, 7, "R9");

        // random mix
        sh = 1;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 199) == 0) sh = $urandom_range(0, 7);
            cyc(($urandom_range(0, 9) < 7), $urandom_range(0, 4095),
                ($urandom_range(0, 19) == 0) ? $urandom_range(0, 2) : m_tag,
                sh, "R3 random");
        end

        finish_run();
    end

endmodule